// File: doc/BRIEF.md
# Cipher Context Capture and Release Register Bank

This block sits between a block-cipher engine and the processor bus. When the engine finishes an operation while context saving is switched on, the bank latches the 128-bit chaining value and the 128-bit authentication tag the engine presents. It then raises a ready flag. Software reads the captured values back as 32-bit words. Software may also write the chaining-value words to preload the starting counter or IV for the next run, and the bank drives that value to the engine.

The ready flag is an interlock. While it is set, the engine may not begin a new operation. A start request that arrives in that window is remembered and released once the flag drops. The flag drops only as a side effect of software reading the last word of either the IV bank or the tag bank. This ensures a saved context is never overwritten before it has been collected. The cipher datapath is outside this block and is represented by a done strobe together with the IV and tag inputs.

Top module: `ctxSaveBank`

## Requirements
- R1: After reset the ready flag is 0, startAllowed is 1, the control word reads 0, and every IV and tag word reads 0.
- R2: When engDone is high and the save-enable bit is 1, the bank captures engIvIn and engTagIn at that clock edge and sets the ready flag. IV word i at address 4+i and tag word i at address 8+i read bits [32i+31:32i] of the captured values.
- R3: A done strobe while the save-enable bit is 0 captures nothing and leaves the ready flag at 0.
- R4: A write to address 4+i (i = 0..3) loads IV word i. The value reads back at that address and appears on engIvOut bits [32i+31:32i].
- R5: A read of address 7 (IV word 3) or address 11 (tag word 3) clears the ready flag at that edge. Reads of words 0 to 2 leave the flag unchanged, and a read of word 3 with the flag already clear has no effect.
- R6: startAllowed is the inverse of the ready flag. While the flag is set, engStartGo stays low. While it is clear, engStartGo follows engStartReq in the same cycle.
- R7: A start request seen while the flag is set is held. In the first cycle after the flag clears, engStartGo is high for exactly one cycle without any new request.
- R8: If a capture and a read of word 3 fall on the same edge, the capture wins. The flag stays set and the new values are held.
- R9: Writing the control word with bit 2 set clears, in one cycle, the flag, the save-enable bit, all IV and tag words, and any held start request.
- R10: The control word is at address 0. Bit 0 is save-enable (read/write), bit 1 is the ready flag (read-only), and bit 2 is the soft reset (write-only, reads 0). Writes to tag words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Bus write strobe |
| regRdEn | input | 1 | Bus read strobe (side effects at the clock edge) |
| regAddr | input | 4 | Word address |
| regWrData | input | WORD_W | Bus write data |
| regRdData | output | WORD_W | Bus read data for regAddr, combinational |
| engDone | input | 1 | Engine finished an operation |
| engIvIn | input | 4*WORD_W | Chaining value from the engine |
| engTagIn | input | 4*WORD_W | Tag from the engine |
| engStartReq | input | 1 | Engine asks to begin an operation |
| engStartGo | output | 1 | Start granted this cycle |
| startAllowed | output | 1 | High when no saved context is pending |
| ctxReady | output | 1 | Saved-context-ready flag |
| engIvOut | output | 4*WORD_W | Starting IV presented to the engine |

## Verification
The hardest case to reach is the collision between a fresh capture and the releasing read of word 3 on the same edge. It needs a done strobe and a bus read lined up exactly, while a previous context is still unread. The bench drives both strobes in one cycle from a single task and then reads back word 0 to confirm the new capture survived. The deferred start is reached by raising a request only while the flag is set, dropping it, and watching for the one-cycle grant after the clearing read.

// File: rtl/ctxSaveBank_pkg.sv
package ctxSaveBank_pkg;
  localparam int CTX_WORDS = 4;
  localparam int WORD_SEL_W = $clog2(CTX_WORDS);
  localparam int ADDR_W = WORD_SEL_W + 2;
  localparam logic [1:0] BANK_CTRL = 2'd0;
  localparam logic [1:0] BANK_IV = 2'd1;
  localparam logic [1:0] BANK_TAG = 2'd2;
  localparam int CTL_SAVE_BIT = 0;
  localparam int CTL_READY_BIT = 1;
  localparam int CTL_RESET_BIT = 2;
  localparam logic [WORD_SEL_W-1:0] LAST_WORD = WORD_SEL_W'(CTX_WORDS - 1);

  typedef struct packed {
    logic capture;
    logic softReset;
    logic [CTX_WORDS-1:0] ivWrite;
  } bankStrobes_t;
endpackage

// File: rtl/ctxSaveBank_ctl.sv
module ctxSaveBank_ctl
  import ctxSaveBank_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic regWrEn,
  input  logic regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [2:0] ctlWrBits,
  input  logic engDone,
  input  logic engStartReq,
  output bankStrobes_t strb,
  output logic ctxReady,
  output logic saveEn,
  output logic startGo
);
  logic [1:0] bankSel;
  logic [WORD_SEL_W-1:0] wordSel;
  logic isCtlWr;
  logic rdLast;
  logic pendStart;

  assign bankSel = regAddr[ADDR_W-1 -: 2];
  assign wordSel = regAddr[WORD_SEL_W-1:0];

  always_comb begin
    isCtlWr = regWrEn && (bankSel == BANK_CTRL) && (wordSel == '0);
    rdLast = regRdEn && (wordSel == LAST_WORD) &&
             ((bankSel == BANK_IV) || (bankSel == BANK_TAG));
    strb.softReset = isCtlWr && ctlWrBits[CTL_RESET_BIT];
    strb.capture = engDone && saveEn && !strb.softReset;
    for (int w = 0; w < CTX_WORDS; w++) begin
      strb.ivWrite[w] = regWrEn && (bankSel == BANK_IV) &&
                        (wordSel == WORD_SEL_W'(w)) && !strb.softReset;
    end
    startGo = !ctxReady && (engStartReq || pendStart);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctxReady <= 1'b0;
      saveEn <= 1'b0;
      pendStart <= 1'b0;
    end else if (strb.softReset) begin
      ctxReady <= 1'b0;
      saveEn <= 1'b0;
      pendStart <= 1'b0;
    end else begin
      if (isCtlWr) saveEn <= ctlWrBits[CTL_SAVE_BIT];
      if (strb.capture) ctxReady <= 1'b1;
      else if (rdLast) ctxReady <= 1'b0;
      if (ctxReady && engStartReq) pendStart <= 1'b1;
      else if (startGo) pendStart <= 1'b0;
    end
  end
endmodule

// File: rtl/ctxSaveBank_dp.sv
module ctxSaveBank_dp
  import ctxSaveBank_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int BLK_W = WORD_W * CTX_WORDS
) (
  input  logic clk,
  input  logic rstN,
  input  bankStrobes_t strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  input  logic [BLK_W-1:0] engIvIn,
  input  logic [BLK_W-1:0] engTagIn,
  input  logic ctxReady,
  input  logic saveEn,
  output logic [WORD_W-1:0] regRdData,
  output logic [BLK_W-1:0] engIvOut
);
  logic [WORD_W-1:0] ivReg [CTX_WORDS];
  logic [WORD_W-1:0] tagReg [CTX_WORDS];
  logic [WORD_W-1:0] ctlWord;
  logic [1:0] bankSel;
  logic [WORD_SEL_W-1:0] wordSel;

  for (genvar w = 0; w < CTX_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ivReg[w] <= '0;
        tagReg[w] <= '0;
      end else if (strb.softReset) begin
        ivReg[w] <= '0;
        tagReg[w] <= '0;
      end else if (strb.capture) begin
        ivReg[w] <= engIvIn[w*WORD_W +: WORD_W];
        tagReg[w] <= engTagIn[w*WORD_W +: WORD_W];
      end else if (strb.ivWrite[w]) begin
        ivReg[w] <= regWrData;
      end
    end
    assign engIvOut[w*WORD_W +: WORD_W] = ivReg[w];
  end

  assign bankSel = regAddr[ADDR_W-1 -: 2];
  assign wordSel = regAddr[WORD_SEL_W-1:0];

  always_comb begin
    ctlWord = '0;
    ctlWord[CTL_SAVE_BIT] = saveEn;
    ctlWord[CTL_READY_BIT] = ctxReady;
    unique case (bankSel)
      BANK_CTRL: regRdData = (wordSel == '0) ? ctlWord : '0;
      BANK_IV:   regRdData = ivReg[wordSel];
      BANK_TAG:  regRdData = tagReg[wordSel];
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/ctxSaveBank.sv
module ctxSaveBank
  import ctxSaveBank_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int BLK_W = WORD_W * CTX_WORDS
) (
  input  logic clk,
  input  logic rstN,
  input  logic regWrEn,
  input  logic regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  logic engDone,
  input  logic [BLK_W-1:0] engIvIn,
  input  logic [BLK_W-1:0] engTagIn,
  input  logic engStartReq,
  output logic engStartGo,
  output logic startAllowed,
  output logic ctxReady,
  output logic [BLK_W-1:0] engIvOut
);
  bankStrobes_t strb;
  logic saveEn;

  ctxSaveBank_ctl u_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .ctlWrBits(regWrData[2:0]), .engDone(engDone),
    .engStartReq(engStartReq), .strb(strb), .ctxReady(ctxReady),
    .saveEn(saveEn), .startGo(engStartGo)
  );

  ctxSaveBank_dp #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr),
    .regWrData(regWrData), .engIvIn(engIvIn), .engTagIn(engTagIn),
    .ctxReady(ctxReady), .saveEn(saveEn), .regRdData(regRdData),
    .engIvOut(engIvOut)
  );

  assign startAllowed = !ctxReady;
endmodule

// File: rtl/ctxSaveBank_chk.sv
module ctxSaveBank_chk
  import ctxSaveBank_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input logic clk,
  input logic rstN,
  input logic regWrEn,
  input logic regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [WORD_W-1:0] regWrData,
  input logic engDone,
  input logic engStartReq,
  input logic engStartGo,
  input logic ctxReady,
  input logic saveEn
);
  logic rdLast;
  logic swRst;

  assign rdLast = regRdEn && ((regAddr == ADDR_W'(7)) || (regAddr == ADDR_W'(11)));
  assign swRst = regWrEn && (regAddr == '0) && regWrData[2];

  p_ready_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctxReady) |-> $past(engDone && saveEn));

  p_ready_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctxReady) |-> $past(rdLast || swRst));

  p_start_blocked_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctxReady |-> !engStartGo);

  p_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctxReady && engStartReq && !swRst) |=> (ctxReady || engStartGo));

  p_done_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (engDone && saveEn && rdLast && !swRst) |=> ctxReady);

  p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rstN)
    swRst |=> (!ctxReady && !saveEn));
endmodule

bind ctxSaveBank ctxSaveBank_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .regWrData(regWrData), .engDone(engDone),
  .engStartReq(engStartReq), .engStartGo(engStartGo), .ctxReady(ctxReady),
  .saveEn(saveEn)
);

// File: tb/ctxSaveBank_test.sv
`timescale 1ns/1ps
module ctxSaveBank_test;
  import ctxSaveBank_pkg::*;

  localparam int W = 32;
  localparam int BW = W * CTX_WORDS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic regRdEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [W-1:0] regWrData = '0;
  logic [W-1:0] regRdData;
  logic engDone = 1'b0;
  logic [BW-1:0] engIvIn = '0;
  logic [BW-1:0] engTagIn = '0;
  logic engStartReq = 1'b0;
  logic engStartGo, startAllowed, ctxReady;
  logic [BW-1:0] engIvOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  ctxSaveBank uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .engDone(engDone), .engIvIn(engIvIn), .engTagIn(engTagIn),
    .engStartReq(engStartReq), .engStartGo(engStartGo),
    .startAllowed(startAllowed), .ctxReady(ctxReady), .engIvOut(engIvOut)
  );

  always #5 clk = ~clk;

  localparam logic [ADDR_W-1:0] A_CTL = 4'd0;
  localparam logic [ADDR_W-1:0] A_IV0 = 4'd4;
  localparam logic [ADDR_W-1:0] A_IV3 = 4'd7;
  localparam logic [ADDR_W-1:0] A_TAG0 = 4'd8;
  localparam logic [ADDR_W-1:0] A_TAG3 = 4'd11;

  localparam logic [BW-1:0] IV_A = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
  localparam logic [BW-1:0] TAG_A = 128'h11112222_33334444_55556666_77778888;
  localparam logic [BW-1:0] IV_B = 128'hdeadbeef_cafef00d_01234567_89abcdef;
  localparam logic [BW-1:0] TAG_B = 128'ha5a5a5a5_5a5a5a5a_f0f0f0f0_0f0f0f0f;

  task automatic check(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [ADDR_W-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic busRd(input logic [ADDR_W-1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(posedge clk); #1;
    regRdEn = 1'b0;
  endtask

  task automatic pulseDone(input logic [BW-1:0] iv, input logic [BW-1:0] tag);
    @(negedge clk);
    engDone = 1'b1; engIvIn = iv; engTagIn = tag;
    @(posedge clk); #1;
    engDone = 1'b0;
  endtask

  task automatic testReset();
    logic [W-1:0] d;
    check("R1 ready", ctxReady, 0);
    check("R1 startAllowed", startAllowed, 1);
    busRd(A_CTL, d);  check("R1 ctrl word", d, 0);
    busRd(A_IV0, d);  check("R1 iv0", d, 0);
    busRd(A_TAG3, d); check("R1 tag3", d, 0);
  endtask

  task automatic testIvLoad();
    logic [W-1:0] d;
    for (int i = 0; i < CTX_WORDS; i++) busWr(A_IV0 + ADDR_W'(i), IV_B[i*W +: W]);
    for (int i = 0; i < CTX_WORDS; i++) begin
      busRd(A_IV0 + ADDR_W'(i), d);
      check("R4 iv readback", d, IV_B[i*W +: W]);
    end
    check("R4 engIvOut", engIvOut, IV_B);
  endtask

  task automatic testNoSave();
    logic [W-1:0] d;
    pulseDone(IV_A, TAG_A);
    check("R3 ready stays clear", ctxReady, 0);
    busRd(A_IV0, d);  check("R3 iv not captured", d, IV_B[W-1:0]);
    busRd(A_TAG0, d); check("R3 tag not captured", d, 0);
  endtask

  task automatic testCapture();
    logic [W-1:0] d;
    busWr(A_CTL, 32'h1);
    busRd(A_CTL, d); check("R10 save bit", d, 32'h1);
    pulseDone(IV_A, TAG_A);
    check("R2 ready set", ctxReady, 1);
    check("R6 startAllowed low", startAllowed, 0);
    busRd(A_CTL, d); check("R10 ready bit", d, 32'h3);
    for (int i = 0; i < CTX_WORDS - 1; i++) begin
      busRd(A_IV0 + ADDR_W'(i), d);  check("R2 iv word", d, IV_A[i*W +: W]);
      busRd(A_TAG0 + ADDR_W'(i), d); check("R2 tag word", d, TAG_A[i*W +: W]);
    end
    check("R5 partial reads keep flag", ctxReady, 1);
    busRd(A_TAG3, d); check("R2 tag word3", d, TAG_A[3*W +: W]);
    check("R5 tag3 read clears", ctxReady, 0);
    check("R6 startAllowed back", startAllowed, 1);
  endtask

  task automatic testIvLastClears();
    logic [W-1:0] d;
    pulseDone(IV_B, TAG_B);
    check("R2 ready set again", ctxReady, 1);
    busRd(A_IV3, d); check("R2 iv word3", d, IV_B[3*W +: W]);
    check("R5 iv3 read clears", ctxReady, 0);
    busRd(A_IV3, d);
    check("R5 iv3 read when clear", ctxReady, 0);
  endtask

  task automatic testStartHold();
    logic [W-1:0] d;
    @(negedge clk);
    engStartReq = 1'b1;
    #1 check("R6 start passes when clear", engStartGo, 1);
    @(posedge clk); #1;
    engStartReq = 1'b0;
    #1 check("R6 no grant without request", engStartGo, 0);
    pulseDone(IV_A, TAG_A);
    @(negedge clk);
    engStartReq = 1'b1;
    #1 check("R6 start held while ready", engStartGo, 0);
    @(posedge clk); #1;
    engStartReq = 1'b0;
    #1 check("R7 still held", engStartGo, 0);
    busRd(A_IV3, d);
    check("R7 ready cleared", ctxReady, 0);
    check("R7 held start released", engStartGo, 1);
    @(posedge clk); #1;
    check("R7 release lasts one cycle", engStartGo, 0);
  endtask

  task automatic testCollision();
    logic [W-1:0] d;
    pulseDone(IV_A, TAG_A);
    @(negedge clk);
    engDone = 1'b1; engIvIn = IV_B; engTagIn = TAG_B;
    regRdEn = 1'b1; regAddr = A_IV3;
    #1 check("R8 old word3 seen", regRdData, IV_A[3*W +: W]);
    @(posedge clk); #1;
    engDone = 1'b0; regRdEn = 1'b0;
    check("R8 done wins", ctxReady, 1);
    busRd(A_IV0, d);  check("R8 new iv kept", d, IV_B[W-1:0]);
    busRd(A_TAG0, d); check("R8 new tag kept", d, TAG_B[W-1:0]);
    busRd(A_TAG3, d);
    check("R5 cleared after collision", ctxReady, 0);
  endtask

  task automatic testReadOnly();
    logic [W-1:0] d;
    busWr(A_TAG0, 32'h12345678);
    busRd(A_TAG0, d); check("R10 tag write ignored", d, TAG_B[W-1:0]);
    busWr(A_CTL, 32'h3);
    check("R10 ready bit not writable", ctxReady, 0);
    busRd(A_CTL, d); check("R10 ctrl after write", d, 32'h1);
  endtask

  task automatic testSoftReset();
    logic [W-1:0] d;
    pulseDone(IV_A, TAG_A);
    @(negedge clk);
    engStartReq = 1'b1;
    @(posedge clk); #1;
    engStartReq = 1'b0;
    busWr(A_CTL, 32'h4);
    check("R9 ready cleared", ctxReady, 0);
    check("R9 held start dropped", engStartGo, 0);
    check("R9 engIvOut cleared", engIvOut, 0);
    busRd(A_CTL, d);  check("R9 ctrl cleared", d, 0);
    busRd(A_IV0, d);  check("R9 iv cleared", d, 0);
    busRd(A_TAG0, d); check("R9 tag cleared", d, 0);
    pulseDone(IV_B, TAG_B);
    check("R9 save disabled after reset", ctxReady, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testIvLoad();
    testNoSave();
    testCapture();
    testIvLastClears();
    testStartHold();
    testCollision();
    testReadOnly();
    testSoftReset();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule